// File: doc/BRIEF.md
# Priority Ramp Metering Arbiter

This block decides which of three parallel on-ramp lanes gets a green light. The lanes are a car-pool lane, a left lane and a right lane. Each lane has a car-present sensor bit and a light bit, where 1 means green and 0 means red. The car-pool lane always wins. The left and right lanes share service, and a round-robin select settles the case where both request while the car-pool lane is empty. At most one light is green at any time.

The arbitration itself is combinational. A build parameter picks one of two variants. In the registered variant, the lights come from flip-flops and the round-robin select is an internal bit that alternates on its own. In the combinational variant, the lights follow the sensors in the same cycle and the select comes from a pin. Sensor debouncing and light timing belong to the logic around this block.

Top module: `ramp_meter_top`

## Requirements
- R1: While the car-pool sensor is 1, the car-pool light is 1 and both the left and right lights are 0, whatever the other sensors and the select hold.
- R2: With the car-pool and right sensors at 0 and the left sensor at 1, only the left light is 1.
- R3: With the car-pool and left sensors at 0 and the right sensor at 1, only the right light is 1.
- R4: With the car-pool sensor at 0 and both side sensors at 1 (contention), the left light is 1 when the select is 1 and the right light is 1 when the select is 0; the other side stays 0.
- R5: With no sensor at 1, all three lights are 0.
- R6: No more than one of the three lights is 1 in any cycle.
- R7: In the registered variant (REGISTERED=1), the lights in a cycle are the decision for the sensor values sampled at the previous rising clock edge, and all lights are 0 while rst_n is low.
- R8: In the registered variant, the select is an internal bit that is 1 (left) after reset. It inverts at every clock edge that samples contention and holds at all other edges, so sustained contention alternates left, right, left and so on. The rr_sel_in pin has no effect in this variant.
- R9: In the combinational variant (REGISTERED=0), the lights follow the present sensor and rr_sel_in values with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge (registered variant) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pool_car | input | 1 | Car-pool lane sensor, 1 = car present |
| left_car | input | 1 | Left lane sensor, 1 = car present |
| right_car | input | 1 | Right lane sensor, 1 = car present |
| rr_sel_in | input | 1 | External select for the combinational variant, 1 = left, 0 = right |
| pool_go | output | 1 | Car-pool lane light, 1 = green |
| left_go | output | 1 | Left lane light, 1 = green |
| right_go | output | 1 | Right lane light, 1 = green |

## Verification
The internal select of the registered variant is the hard part. It shows at the ports only in a cycle that follows contention, so a wrong advance only shows up later, at the next contended cycle. A design can wrongly flip the select when the car-pool lane preempts a two-sided request, or when only one side requests, and this is invisible until then. The stimulus therefore places car-pool preemptions and single-side requests between runs of contention. It also includes an exhaustive sweep of all sixteen input codes, a long pseudo-random stretch and a reset taken in the middle of contention. A behavioural model in the bench predicts each next light from the previous edge's sensors.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

  // One bit per lane, ordered by priority: pool highest.
  typedef struct packed {
    logic pool;
    logic left;
    logic right;
  } lane_bits_t;

  localparam int unsigned LANE_COUNT = $bits(lane_bits_t);

  localparam lane_bits_t LANES_DARK = '{pool: 1'b0, left: 1'b0, right: 1'b0};

endpackage

// File: rtl/ramp_grant_logic.sv
module ramp_grant_logic
  import ramp_pkg::*;
(
  input  lane_bits_t req,
  input  logic       prefer_left,
  output lane_bits_t grant,
  output logic       contend
);

  logic side_any;

  always_comb begin
    grant    = LANES_DARK;
    side_any = req.left | req.right;
    contend  = ~req.pool & req.left & req.right;
    if (req.pool) begin
      grant.pool = 1'b1;
    end else if (contend) begin
      grant.left  = prefer_left;
      grant.right = ~prefer_left;
    end else if (side_any) begin
      grant.left  = req.left;
      grant.right = req.right;
    end
  end

endmodule

// File: rtl/ramp_rr_toggle.sv
module ramp_rr_toggle #(
  parameter bit RESET_LEFT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic prefer_left
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prefer_left <= RESET_LEFT;
    end else if (advance) begin
      prefer_left <= ~prefer_left;
    end
  end

endmodule

// File: rtl/ramp_out_stage.sv
module ramp_out_stage
  import ramp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lane_bits_t d,
  output lane_bits_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= LANES_DARK;
    end else begin
      q <= d;
    end
  end

endmodule

// File: rtl/ramp_meter_top.sv
module ramp_meter_top
  import ramp_pkg::*;
#(
  parameter bit REGISTERED = 1'b1,
  parameter bit RR_RESET_LEFT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pool_car,
  input  logic left_car,
  input  logic right_car,
  input  logic rr_sel_in,
  output logic pool_go,
  output logic left_go,
  output logic right_go
);

  lane_bits_t req;
  lane_bits_t grant;
  lane_bits_t lights;
  logic       prefer_left;
  logic       contend;

  assign req = '{pool: pool_car, left: left_car, right: right_car};

  ramp_grant_logic u_grant (
    .req        (req),
    .prefer_left(prefer_left),
    .grant      (grant),
    .contend    (contend)
  );

  generate
    if (REGISTERED) begin : g_registered
      logic unused_rr_sel;
      assign unused_rr_sel = rr_sel_in;

      ramp_rr_toggle #(.RESET_LEFT(RR_RESET_LEFT)) u_rr (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (contend),
        .prefer_left(prefer_left)
      );

      ramp_out_stage u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (grant),
        .q    (lights)
      );
    end else begin : g_direct
      logic unused_clocking;
      assign unused_clocking = clk ^ rst_n ^ contend;
      assign prefer_left     = rr_sel_in;
      assign lights          = grant;
    end
  endgenerate

  assign pool_go  = lights.pool;
  assign left_go  = lights.left;
  assign right_go = lights.right;

endmodule

// File: rtl/ramp_meter_checker.sv
module ramp_meter_checker #(
  parameter bit REGISTERED = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic pool_car,
  input logic left_car,
  input logic right_car,
  input logic rr_sel_in,
  input logic pool_go,
  input logic left_go,
  input logic right_go
);

  logic [1:0] live_q;
  logic       contend_w;
  logic       idle_w;

  assign contend_w = ~pool_car & left_car & right_car;
  assign idle_w    = ~pool_car & ~left_car & ~right_car;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 2'd0;
    end else if (live_q != 2'd2) begin
      live_q <= live_q + 2'd1;
    end
  end

  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pool_go, left_go, right_go})); // R6

  generate
    if (REGISTERED) begin : g_reg_chk
      AST_POOL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q != 2'd0 && $past(pool_car)) |-> (pool_go && !left_go && !right_go)); // R1
      AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q != 2'd0 && $past(idle_w)) |-> !(pool_go || left_go || right_go)); // R5
      AST_CONTEND_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd2 && $past(contend_w) && $past(contend_w, 2)) |-> (left_go != $past(left_go))); // R8
    end else begin : g_dir_chk
      AST_POOL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        pool_car |-> (pool_go && !left_go && !right_go)); // R1
      AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        idle_w |-> !(pool_go || left_go || right_go)); // R5
      AST_CONTEND_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        contend_w |-> (left_go == rr_sel_in && right_go == !rr_sel_in)); // R4
    end
  endgenerate

endmodule

bind ramp_meter_top ramp_meter_checker #(.REGISTERED(REGISTERED)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pool_car (pool_car),
  .left_car (left_car),
  .right_car(right_car),
  .rr_sel_in(rr_sel_in),
  .pool_go  (pool_go),
  .left_go  (left_go),
  .right_go (right_go)
);

// File: tb/sim_ramp_meter_top.sv
`timescale 1ns/1ps
module sim_ramp_meter_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pool_car = 1'b0, left_car = 1'b0, right_car = 1'b0, rr_sel_in = 1'b0;
  logic r_pool, r_left, r_right;
  logic c_pool, c_left, c_right;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ramp_meter_top #(.REGISTERED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .pool_car(pool_car), .left_car(left_car),
    .right_car(right_car), .rr_sel_in(rr_sel_in),
    .pool_go(r_pool), .left_go(r_left), .right_go(r_right));

  ramp_meter_top #(.REGISTERED(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .pool_car(pool_car), .left_car(left_car),
    .right_car(right_car), .rr_sel_in(rr_sel_in),
    .pool_go(c_pool), .left_go(c_left), .right_go(c_right));

  // Behavioural reference: index of the lit lane (0 none, 1 pool, 2 left, 3 right).
  function automatic int pick(bit p, bit l, bit r, bit sel);
    if (p) return 1;
    if (l && r) return sel ? 2 : 3;
    if (l) return 2;
    if (r) return 3;
    return 0;
  endfunction

  function automatic string tag_of(bit p, bit l, bit r);
    if (p) return "R1";
    if (l && r) return "R4";
    if (l) return "R2";
    if (r) return "R3";
    return "R5";
  endfunction

  int    m_lit = 0;
  bit    m_rr = 1'b1;
  string m_tag = "R7";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lit = 0;
      m_rr  = 1'b1;
      m_tag = "R7";
    end else begin
      m_lit = pick(pool_car, left_car, right_car, m_rr);
      m_tag = (!pool_car && left_car && right_car) ? "R8" : tag_of(pool_car, left_car, right_car);
      if (!pool_car && left_car && right_car) m_rr = ~m_rr;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int lit_of(logic p, logic l, logic r);
    if ({p, l, r} == 3'b100) return 1;
    if ({p, l, r} == 3'b010) return 2;
    if ({p, l, r} == 3'b001) return 3;
    if ({p, l, r} == 3'b000) return 0;
    return 9;
  endfunction

  // Check the registered instance, then apply new inputs and check the direct one.
  task automatic step(bit p, bit l, bit r, bit sel);
    @(negedge clk);
    chk(m_tag, "R7 registered lights", lit_of(r_pool, r_left, r_right), m_lit);
    chk("R6", "registered one-hot", int'($countones({r_pool, r_left, r_right}) <= 1), 1);
    pool_car = p; left_car = l; right_car = r; rr_sel_in = sel;
    #1;
    chk(tag_of(p, l, r), "R9 direct lights", lit_of(c_pool, c_left, c_right), pick(p, l, r, sel));
    chk("R6", "direct one-hot", int'($countones({c_pool, c_left, c_right}) <= 1), 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state: lights dark while rst_n low even with requests (R7).
    step(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7", "lights in reset", lit_of(r_pool, r_left, r_right), 0);
    rst_n = 1'b1;

    // Exhaustive sweep of all sixteen input codes (R1 to R5 each).
    for (int i = 0; i < 16; i++) step(i[3], i[2], i[1], i[0]);

    // Sustained contention with the external select held 0: R8 alternation, pin ignored.
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b1, 1'b0);

    // Pool preempts a two-sided request: select must not move (R8, R1).
    step(1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    // Single-side requests between contentions: select holds (R2, R3, R8).
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b1);

    // Pseudo-random stretch.
    for (int i = 0; i < 600; i++) begin
      int unsigned v = $urandom;
      step(v[0] & v[5], v[1], v[2], v[3]);
    end

    // Reset in the middle of contention restores left preference (R7, R8).
    step(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R7", "lights after async reset", lit_of(r_pool, r_left, r_right), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule